// File: doc/BRIEF.md
# Two-Channel Fault Status and Fault Pin Controller

This block collects live fault and diagnostic conditions from two power-converter channels, plus a few conditions that both channels share. It records them in two sticky status registers and drives two active-low fault pins. Some faults can be switched off one by one through per-channel enable registers. The rest are always active. Software reaches the registers through a small register port, which an SPI slave drives. That slave marks the end of each read response with a strobe.

A status bit clears on read only when the condition behind it has gone. The clear happens when the read response finishes, not when the read command arrives. A bit that sets while a response is in flight is never lost. The feedback-pin-open fault has no status bit of its own and reports through the overvoltage bit of its channel. When sync mode is on, the second fault pin is released for use as a clock input. The faults of both channels then drive the first pin.

Top module: `fault_monitor`

## Requirements
- R1: A present condition sets its status bit at the next clock edge, and the bit stays set until a qualifying clear. Status layout for each channel register: bit0 overvoltage, bit1 undervoltage, bit2 switch current limit, bit3 LED overcurrent, bit4 undercurrent, bit5 sense-pin open. Bit6 is timing-resistor open in register 1 and thermal warning in register 2. Bit7 is power-on reset in register 1 and reads 0 in register 2.
- R2: Enable register layout: bit0 overvoltage, bit1 undervoltage, bit2 current limit, bit3 overcurrent, bit4 sense-pin open, bit5 feedback-pin open. Bits 7:6 read 0. A fault whose enable bit is 0 neither sets a status bit nor pulls a pin.
- R3: Feedback-pin open sets the overvoltage bit (bit0) of its own channel and pulls that channel's pin. It sets no other bit.
- R4: A status register clears only when the response-done strobe arrives after a read command to that register. A read command alone does not clear it. Neither does a done strobe with no pending read.
- R5: At that clear, only bits that were set in the read data and whose condition is absent are cleared. A bit whose condition is still present stays set, and its pin stays low.
- R6: A bit that sets after the read command but before the done strobe survives the clear.
- R7: With sync off, pin 1 is low when a channel-1 pin fault or a shared pin fault is present, and pin 2 likewise for channel 2. The pin follows one clock edge after the condition. Thermal shutdown and timing-resistor open pull both pins. Undercurrent and thermal warning pull no pin.
- R8: Control register bit0 selects sync mode. In sync mode, pin 1 is low when any fault of either channel is present. Pin 2 is held high with its output enable low.
- R9: After reset the power-on-reset bit is set, and both pins are low until a read clears that bit.
- R10: Register addresses: 0 and 1 are the channel enables (reset 0x3F), 2 and 3 the status registers, 4 the control register (reset 0). Writes to status registers are ignored, and other addresses read 0. Read data appears one edge after the read command and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_ov | input | 2 | Overvoltage condition, bit i = channel i+1 |
| cond_uv | input | 2 | Undervoltage condition |
| cond_ilim | input | 2 | Switch current limit condition |
| cond_oc | input | 2 | LED overcurrent condition |
| cond_uc | input | 2 | LED undercurrent diagnostic |
| cond_isn_open | input | 2 | Current-sense pin open |
| cond_fb_open | input | 2 | Feedback pin open |
| cond_rt_open | input | 1 | Timing-resistor pin open (shared) |
| cond_therm_warn | input | 1 | Thermal warning (shared) |
| cond_therm_sd | input | 1 | Thermal shutdown (shared) |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read command strobe |
| rsp_done | input | 1 | End-of-read-response strobe |
| reg_rdata | output | 8 | Read data |
| flt1_n | output | 1 | Fault pin 1, active low |
| flt2_n | output | 1 | Fault pin 2, active low |
| flt2_oe | output | 1 | Pin 2 output enable (0 in sync mode) |

## Verification
The assertions assume that condition inputs, strobes and the address are synchronous to the clock and settle before each rising edge. They also assume that a done strobe, when one is sent, comes no earlier than one edge after its read command. Under those assumptions they check that status bits hold without a clear, that live conditions always set their bits, and how the pins behave. The bench changes every input at the falling edge and waits at least one full edge between a read command and its done strobe. It raises conditions in the middle of a read response on purpose, to exercise the survive-the-clear case inside those rules.

// File: rtl/fsr_pkg.sv
// Package: shared constants, register addresses and bit positions for the
// fault status block. Assumes exactly two channels (the pin logic is wired
// for two pins).
package fsr_pkg;
    localparam int NCH = 2;
    localparam int DW  = 8;
    localparam int AW  = 3;

    localparam logic [AW-1:0] ADDR_EN_BASE   = 3'd0;
    localparam logic [AW-1:0] ADDR_STAT_BASE = 3'd2;
    localparam logic [AW-1:0] ADDR_CTRL      = 3'd4;

    // status bit positions
    localparam int SB_OV  = 0;
    localparam int SB_UV  = 1;
    localparam int SB_ILM = 2;
    localparam int SB_OC  = 3;
    localparam int SB_UC  = 4;
    localparam int SB_ISN = 5;
    localparam int SB_SH0 = 6;
    localparam int SB_SH1 = 7;

    // enable bit positions
    localparam int EB_OV  = 0;
    localparam int EB_UV  = 1;
    localparam int EB_ILM = 2;
    localparam int EB_OC  = 3;
    localparam int EB_ISN = 4;
    localparam int EB_FB  = 5;
    localparam int EN_BITS = 6;

    localparam logic [DW-1:0] EN_RST  = DW'((1 << EN_BITS) - 1);
    localparam logic [DW-1:0] POR_VAL = DW'(1 << SB_SH1);

    typedef struct packed {
        logic ov;
        logic uv;
        logic ilim;
        logic oc;
        logic uc;
        logic isn;
        logic fb;
    } chan_cond_t;
endpackage

// File: rtl/fsr_chan_gate.sv
// Module: per-channel gating. Applies the enable bits to the raw conditions
// of one channel and produces the status set vector and the pin pull request.
// Assumes shared status bits arrive already placed in sh_set.
module fsr_chan_gate
    import fsr_pkg::*;
(
    input  chan_cond_t      cond,
    input  logic [DW-1:0]   en,
    input  logic [1:0]      sh_set,
    output logic [DW-1:0]   set_vec,
    output logic            pull
);
    logic g_ov, g_uv, g_ilm, g_oc, g_isn, g_fb;

    // gate each enable-able fault with its enable bit
    always_comb begin
        g_ov  = cond.ov   & en[EB_OV];
        g_uv  = cond.uv   & en[EB_UV];
        g_ilm = cond.ilim & en[EB_ILM];
        g_oc  = cond.oc   & en[EB_OC];
        g_isn = cond.isn  & en[EB_ISN];
        g_fb  = cond.fb   & en[EB_FB];
    end

    // build the status set vector; feedback-open aliases onto overvoltage
    always_comb begin
        set_vec         = '0;
        set_vec[SB_OV]  = g_ov | g_fb;
        set_vec[SB_UV]  = g_uv;
        set_vec[SB_ILM] = g_ilm;
        set_vec[SB_OC]  = g_oc;
        set_vec[SB_UC]  = cond.uc;
        set_vec[SB_ISN] = g_isn;
        set_vec[SB_SH0] = sh_set[0];
        set_vec[SB_SH1] = sh_set[1];
    end

    // undercurrent is a diagnostic and pulls no pin
    always_comb begin
        pull = g_ov | g_uv | g_ilm | g_oc | g_isn | g_fb;
    end
endmodule

// File: rtl/fsr_sticky.sv
// Module: one sticky status register. Bits set from a live set vector; a
// clear strobe removes the snapshot bits whose condition is absent.
// Assumes clr_snap is the value software was shown for this register.
module fsr_sticky
    import fsr_pkg::*;
#(
    parameter logic [DW-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   set_vec,
    input  logic            clr_en,
    input  logic [DW-1:0]   clr_snap,
    output logic [DW-1:0]   stat_q
);
    logic [DW-1:0] clr_mask;

    // bits eligible for clearing: reported and no longer present
    always_comb begin
        clr_mask = clr_en ? (clr_snap & ~set_vec) : '0;
    end

    // sticky register update
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= RST_VAL;
        else        stat_q <= (stat_q & ~clr_mask) | set_vec;
    end

    // R1: without a clear strobe no set bit drops
    assert_sticky_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R5: a live condition always leaves its bit set, even during a clear
    assert_live_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/fsr_regs.sv
// Module: register port. Holds enable and control registers, returns read
// data one edge after a read command, and tracks the pending status read so
// the clear fires at the response-done strobe. Assumes single-cycle strobes.
module fsr_regs
    import fsr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           reg_addr,
    input  logic                    reg_wr,
    input  logic [DW-1:0]           reg_wdata,
    input  logic                    reg_rd,
    input  logic                    rsp_done,
    input  logic [NCH-1:0][DW-1:0]  stat,
    output logic [NCH-1:0][DW-1:0]  en_q,
    output logic                    sync_en,
    output logic [DW-1:0]           reg_rdata,
    output logic [NCH-1:0]          clr_en,
    output logic [DW-1:0]           clr_snap
);
    logic [DW-1:0] rd_mux;
    logic          pend_q;
    logic [AW-1:0] pend_addr_q;

    // enable and control register writes; status addresses ignore writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) en_q[i] <= EN_RST;
            sync_en <= 1'b0;
        end else if (reg_wr) begin
            for (int i = 0; i < NCH; i++)
                if (reg_addr == ADDR_EN_BASE + AW'(i))
                    en_q[i] <= reg_wdata & EN_RST;
            if (reg_addr == ADDR_CTRL) sync_en <= reg_wdata[0];
        end
    end

    // read multiplexer; unmapped addresses return zero
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr == ADDR_EN_BASE + AW'(i))   rd_mux = en_q[i];
            if (reg_addr == ADDR_STAT_BASE + AW'(i)) rd_mux = stat[i];
        end
        if (reg_addr == ADDR_CTRL) rd_mux = {{(DW-1){1'b0}}, sync_en};
    end

    // capture read data and remember which register a response is pending for
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata   <= '0;
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
        end else if (reg_rd) begin
            reg_rdata   <= rd_mux;
            pend_q      <= 1'b1;
            pend_addr_q <= reg_addr;
        end else if (rsp_done) begin
            pend_q      <= 1'b0;
        end
    end

    // clear strobe for the status register whose response just ended
    always_comb begin
        for (int i = 0; i < NCH; i++)
            clr_en[i] = rsp_done & pend_q & (pend_addr_q == ADDR_STAT_BASE + AW'(i));
        clr_snap = reg_rdata;
    end

    // R4: a read command always leaves a response pending
    assert_pend_after_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> pend_q);

    // R10: read data changes only on a read command
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

// File: rtl/fsr_pins.sv
// Module: fault pin drivers. Combines per-channel pull requests and shared
// pull into two registered active-low pins; sync mode folds both channels
// onto pin 1 and releases pin 2. Assumes two channels.
module fsr_pins
    import fsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  pull,
    input  logic            shared_pull,
    input  logic            sync_en,
    output logic            flt1_n,
    output logic            flt2_n,
    output logic            flt2_oe
);
    logic any_ch;

    // OR of every channel request, used in sync mode
    always_comb begin
        any_ch = |pull;
    end

    // registered pin drive; reset state reflects the power-on-reset flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt1_n  <= 1'b0;
            flt2_n  <= 1'b0;
            flt2_oe <= 1'b1;
        end else if (sync_en) begin
            flt1_n  <= ~(any_ch | shared_pull);
            flt2_n  <= 1'b1;
            flt2_oe <= 1'b0;
        end else begin
            flt1_n  <= ~(pull[0] | shared_pull);
            flt2_n  <= ~(pull[1] | shared_pull);
            flt2_oe <= 1'b1;
        end
    end

    // R8: in sync mode pin 2 is released
    assert_sync_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_en |=> (!flt2_oe && flt2_n));

    // R8: a channel-2 request lands on pin 1 in sync mode
    assert_sync_fold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && pull[1]) |=> !flt1_n);
endmodule

// File: rtl/fault_monitor.sv
// Module: top of the fault status block. Wires per-channel gating, two
// sticky status registers, the register port and the pin drivers.
// Assumes all inputs are synchronous to clk.
module fault_monitor
    import fsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cond_ov,
    input  logic [1:0]      cond_uv,
    input  logic [1:0]      cond_ilim,
    input  logic [1:0]      cond_oc,
    input  logic [1:0]      cond_uc,
    input  logic [1:0]      cond_isn_open,
    input  logic [1:0]      cond_fb_open,
    input  logic            cond_rt_open,
    input  logic            cond_therm_warn,
    input  logic            cond_therm_sd,
    input  logic [2:0]      reg_addr,
    input  logic            reg_wr,
    input  logic [7:0]      reg_wdata,
    input  logic            reg_rd,
    input  logic            rsp_done,
    output logic [7:0]      reg_rdata,
    output logic            flt1_n,
    output logic            flt2_n,
    output logic            flt2_oe
);
    logic [NCH-1:0][DW-1:0] stat;
    logic [NCH-1:0][DW-1:0] en_q;
    logic [NCH-1:0][DW-1:0] set_vec;
    logic [NCH-1:0]         pull;
    logic [NCH-1:0]         clr_en;
    logic [DW-1:0]          clr_snap;
    logic                   sync_en;
    logic                   shared_pull;

    // shared faults that pull pins: resistor open, shutdown, pending power-on flag
    always_comb begin
        shared_pull = cond_rt_open | cond_therm_sd | stat[0][SB_SH1];
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            chan_cond_t cc;
            logic [1:0] sh;

            // assemble this channel's conditions and its shared status bits
            always_comb begin
                cc.ov   = cond_ov[c];
                cc.uv   = cond_uv[c];
                cc.ilim = cond_ilim[c];
                cc.oc   = cond_oc[c];
                cc.uc   = cond_uc[c];
                cc.isn  = cond_isn_open[c];
                cc.fb   = cond_fb_open[c];
                sh      = (c == 0) ? {1'b0, cond_rt_open} : {1'b0, cond_therm_warn};
            end

            fsr_chan_gate u_gate (
                .cond    (cc),
                .en      (en_q[c]),
                .sh_set  (sh),
                .set_vec (set_vec[c]),
                .pull    (pull[c])
            );

            fsr_sticky #(.RST_VAL((c == 0) ? POR_VAL : '0)) u_stat (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_vec  (set_vec[c]),
                .clr_en   (clr_en[c]),
                .clr_snap (clr_snap),
                .stat_q   (stat[c])
            );
        end
    endgenerate

    fsr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .rsp_done  (rsp_done),
        .stat      (stat),
        .en_q      (en_q),
        .sync_en   (sync_en),
        .reg_rdata (reg_rdata),
        .clr_en    (clr_en),
        .clr_snap  (clr_snap)
    );

    fsr_pins u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .pull        (pull),
        .shared_pull (shared_pull),
        .sync_en     (sync_en),
        .flt1_n      (flt1_n),
        .flt2_n      (flt2_n),
        .flt2_oe     (flt2_oe)
    );

    // R7: thermal shutdown asserts every driven pin one edge later
    assert_tsd_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cond_therm_sd |=> (!flt1_n && (!flt2_n || !flt2_oe)));

    // R3: feedback-open on an enabled channel 1 marks its overvoltage bit
    assert_fb_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_fb_open[0] && en_q[0][EB_FB]) |=> stat[0][SB_OV]);
endmodule

// File: tb/fault_monitor_bench.sv
`timescale 1ns/1ps
module fault_monitor_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cond_ov = '0, cond_uv = '0, cond_ilim = '0, cond_oc = '0;
    logic [1:0] cond_uc = '0, cond_isn_open = '0, cond_fb_open = '0;
    logic cond_rt_open = 1'b0, cond_therm_warn = 1'b0, cond_therm_sd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0, rsp_done = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic flt1_n, flt2_n, flt2_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fault_monitor u_fault_monitor (.*);

    typedef struct packed {
        logic [1:0] ov, uv, ilim, oc, uc, isn, fb;
        logic rt, tw, tsd;
        logic f1, f2;
        logic [7:0] s1, s2;
    } vec_t;

    // stimulus, expected pins, expected status 1 and 2
    localparam vec_t VECS [9] = '{
        '{2'b01,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,8'h01,8'h00},
        '{2'b00,2'b10,2'b00,2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,8'h02},
        '{2'b00,2'b00,2'b11,2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,8'h04,8'h04},
        '{2'b00,2'b00,2'b00,2'b01,2'b00,2'b10,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,8'h08,8'h20},
        '{2'b00,2'b00,2'b00,2'b00,2'b11,2'b00,2'b00,1'b0,1'b0,1'b0,1'b1,1'b1,8'h10,8'h10},
        '{2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b10,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,8'h01},
        '{2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,8'h40,8'h00},
        '{2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,1'b0,1'b1,1'b0,1'b1,1'b1,8'h00,8'h40},
        '{2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // read command, check data, optionally end the response
    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req, input bit done);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        chk(req, reg_rdata, exp);
        if (done) begin
            rsp_done = 1'b1;
            @(negedge clk);
            rsp_done = 1'b0;
        end
    endtask

    task automatic clear_conds();
        cond_ov = '0; cond_uv = '0; cond_ilim = '0; cond_oc = '0;
        cond_uc = '0; cond_isn_open = '0; cond_fb_open = '0;
        cond_rt_open = 0; cond_therm_warn = 0; cond_therm_sd = 0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: power-on flag holds both pins low after reset
        chk("R9 pin1 after reset", {7'd0, flt1_n}, 8'h00);
        chk("R9 pin2 after reset", {7'd0, flt2_n}, 8'h00);
        rd(3'd2, 8'h80, "R9 por bit", 1'b1);
        idle(1);
        chk("R9 pins released", {6'd0, flt1_n, flt2_n}, 8'h03);
        rd(3'd2, 8'h00, "R9 por cleared", 1'b1);

        // R10: register map and reset values
        rd(3'd0, 8'h3F, "R10 en1 reset", 1'b0);
        rd(3'd1, 8'h3F, "R10 en2 reset", 1'b0);
        rd(3'd4, 8'h00, "R10 ctrl reset", 1'b0);
        rd(3'd6, 8'h00, "R10 unmapped", 1'b1);
        wr(3'd3, 8'hFF);
        rd(3'd3, 8'h00, "R10 status write ignored", 1'b1);

        // R1 R3 R7: vector table
        for (int v = 0; v < 9; v++) begin
            @(negedge clk);
            cond_ov = VECS[v].ov; cond_uv = VECS[v].uv; cond_ilim = VECS[v].ilim;
            cond_oc = VECS[v].oc; cond_uc = VECS[v].uc; cond_isn_open = VECS[v].isn;
            cond_fb_open = VECS[v].fb; cond_rt_open = VECS[v].rt;
            cond_therm_warn = VECS[v].tw; cond_therm_sd = VECS[v].tsd;
            @(negedge clk);
            chk($sformatf("R7 vec%0d pin1", v), {7'd0, flt1_n}, {7'd0, VECS[v].f1});
            chk($sformatf("R7 vec%0d pin2", v), {7'd0, flt2_n}, {7'd0, VECS[v].f2});
            clear_conds();
            rd(3'd2, VECS[v].s1, $sformatf("R1 vec%0d stat1", v), 1'b1);
            rd(3'd3, VECS[v].s2, $sformatf("R3 vec%0d stat2", v), 1'b1);
            rd(3'd2, 8'h00, $sformatf("R1 vec%0d stat1 cleared", v), 1'b1);
            rd(3'd3, 8'h00, $sformatf("R1 vec%0d stat2 cleared", v), 1'b1);
        end

        // R2: disabled faults set no bit and pull no pin
        wr(3'd0, 8'h3E);
        wr(3'd1, 8'h1F);
        rd(3'd0, 8'h3E, "R2 en1 readback", 1'b0);
        @(negedge clk);
        cond_ov = 2'b01; cond_fb_open = 2'b10;
        @(negedge clk);
        chk("R2 pins stay high", {6'd0, flt1_n, flt2_n}, 8'h03);
        clear_conds();
        rd(3'd2, 8'h00, "R2 ov disabled no bit", 1'b1);
        rd(3'd3, 8'h00, "R2 fb disabled no bit", 1'b1);
        wr(3'd0, 8'h3F);
        wr(3'd1, 8'h3F);

        // R5: live condition survives the clearing read
        @(negedge clk);
        cond_ov = 2'b01;
        rd(3'd2, 8'h01, "R5 read while live", 1'b1);
        chk("R5 pin still low", {7'd0, flt1_n}, 8'h00);
        rd(3'd2, 8'h01, "R5 bit kept", 1'b1);
        clear_conds();
        rd(3'd2, 8'h01, "R5 bit after release", 1'b1);
        rd(3'd2, 8'h00, "R5 cleared", 1'b1);

        // R6: bit set during the response survives
        @(negedge clk);
        reg_addr = 3'd3; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; cond_uv = 2'b10;
        @(negedge clk);
        cond_uv = 2'b00; rsp_done = 1'b1;
        @(negedge clk);
        rsp_done = 1'b0;
        rd(3'd3, 8'h02, "R6 late bit kept", 1'b1);
        rd(3'd3, 8'h00, "R6 then cleared", 1'b1);

        // R4: no clear without done, nor done without pending read
        @(negedge clk);
        cond_oc = 2'b01;
        @(negedge clk);
        clear_conds();
        rd(3'd2, 8'h08, "R4 first read", 1'b0);
        rd(3'd2, 8'h08, "R4 no clear without done", 1'b1);
        @(negedge clk);
        cond_oc = 2'b01;
        @(negedge clk);
        clear_conds(); rsp_done = 1'b1;
        @(negedge clk);
        rsp_done = 1'b0;
        rd(3'd2, 8'h08, "R4 stray done ignored", 1'b1);
        rd(3'd2, 8'h00, "R4 cleared", 1'b1);

        // R8: sync mode folds channels onto pin 1
        wr(3'd4, 8'h01);
        @(negedge clk);
        chk("R8 pin2 released", {6'd0, flt2_n, flt2_oe}, 8'h02);
        cond_uv = 2'b10;
        @(negedge clk);
        chk("R8 ch2 fault on pin1", {7'd0, flt1_n}, 8'h00);
        chk("R8 pin2 still released", {6'd0, flt2_n, flt2_oe}, 8'h02);
        clear_conds();
        wr(3'd4, 8'h00);
        @(negedge clk);
        chk("R8 pin2 driven again", {6'd0, flt2_n, flt2_oe}, 8'h03);
        rd(3'd3, 8'h02, "R8 status still recorded", 1'b1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule